// File: doc/BRIEF.md
# Common-Mode Noise Corrector

This block removes the event-by-event baseline shift that all channels of one front-end chip share. It runs after pedestal subtraction and before clustering. It works in the chip's native channel order, so a single correction stage is enough. A frame is one event's worth of signed, pedestal-corrected samples, one per chip channel. The frame is stored in full. From the stored statistics the block derives a correction, and it then streams the corrected frame back out in channel order.

Two baseline models can be selected per frame. The flat model uses one offset for the whole chip. The ramp model fits an offset plus a slope against the channel index by least squares. Any sample whose magnitude exceeds a programmable limit is treated as a probable hit and takes no part in the estimate, so that busy events do not pull the baseline. The correction is still subtracted from every channel, hits included. Results are clamped to the signed output range.

The frame is loaded while `busy_o` is low. Correction takes two serial divisions, each lasting `WIDE_W` cycles. The output stream then lasts `N_CH` cycles.

Top module: `cm_corrector`

## Requirements
- R1: With `busy_o` low, each cycle with `in_valid_i` high stores `in_data_i` as the next channel, counting from 0. After channel `N_CH-1` is stored, `busy_o` is high from the next cycle on.
- R2: While `busy_o` is high, `in_valid_i`, `in_data_i`, `mode_i` and `thresh_i` have no effect on the frame being processed or on the frame that follows.
- R3: A sample s joins the estimate only when |s| <= threshold, where the threshold is the unsigned `thresh_i` value presented together with channel 0. A sample at exactly the threshold is accepted.
- R4: Flat model (`mode_i`=0 with channel 0). Let n be the number of accepted samples and Sy their sum. The scaled offset is A = trunc0(Sy·2^F / n), where F = `FRAC_W` and trunc0 rounds toward zero. The slope term is B = 0.
- R5: Ramp model (`mode_i`=1 with channel 0), with n >= 2. The sums Sx, Sxx, Sy and Sxy run over the accepted channel indices i and samples y. The slope is B = trunc0((n·Sxy − Sx·Sy)·2^F / (n·Sxx − Sx²)). The offset is A = trunc0((Sy·2^F − B·Sx) / n).
- R6: In ramp mode with exactly one accepted sample, the block falls back to the flat model, with B = 0.
- R7: With no accepted sample, the correction is zero, so every output equals its input.
- R8: Each output is channel k's input minus floor((A + B·k + 2^(F−1)) / 2^F), clamped to [−2^(OUT_W−1), 2^(OUT_W−1)−1].
- R9: The outputs appear with `out_valid_o` high on `N_CH` consecutive cycles, with `out_chan_o` running 0 to `N_CH-1`. `busy_o` goes low in the same cycle as the last output.
- R10: After reset, `busy_o` and `out_valid_o` are low, and the next accepted sample is channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample present on `in_data_i` |
| in_data_i | input | DATA_W | Signed pedestal-corrected sample |
| mode_i | input | 1 | Baseline model: 0 flat, 1 ramp (taken with channel 0) |
| thresh_i | input | DATA_W | Unsigned hit-rejection magnitude (taken with channel 0) |
| busy_o | output | 1 | Frame being processed; input is ignored |
| out_valid_o | output | 1 | Corrected sample present |
| out_chan_o | output | IDX_W | Channel index of the output sample |
| out_data_o | output | OUT_W | Signed corrected, clamped sample |

## Verification
The bound checker watches the framing on every cycle. `busy_o` may only rise after an accepted sample. The accepted-sample count must stay frozen while the block is busy and never exceed the channel count. The output stream must start at channel 0 and step by one without gaps, and `busy_o` may only fall together with the last channel. The arithmetic is shown only by the bench's frames. These compare every output against an independent model of the two fits and cover hit rejection at the exact threshold, the empty and single-sample fallbacks, clamping at both ends of the range, and a frame loaded while junk input is held during the busy phase.

// File: rtl/cm_pkg.sv
package cm_pkg;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_SLOPE,
    ST_DIV_B,
    ST_OFFS,
    ST_DIV_A,
    ST_OUT
  } cm_state_e;

  typedef enum logic {
    MODE_FLAT = 1'b0,
    MODE_RAMP = 1'b1
  } cm_mode_e;

  // headroom for n*Sxy scaled by 2^frac
  function automatic int unsigned wide_width(int unsigned data_w, int unsigned idx_w,
                                             int unsigned frac_w);
    return data_w + 4 * idx_w + frac_w + 4;
  endfunction

endpackage

// File: rtl/cm_stats.sv
module cm_stats #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned WIDE_W = 36
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     first_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0]        thresh_i,
  output logic [CNT_W-1:0]         n_o,
  output logic signed [WIDE_W-1:0] sx_o,
  output logic signed [WIDE_W-1:0] sxx_o,
  output logic signed [WIDE_W-1:0] sy_o,
  output logic signed [WIDE_W-1:0] sxy_o
);

  logic [DATA_W-1:0]        mag;
  logic                     keep;
  logic signed [WIDE_W-1:0] s_w, i_w;
  logic [CNT_W-1:0]         n_q, n_base;
  logic signed [WIDE_W-1:0] sx_q, sxx_q, sy_q, sxy_q;
  logic signed [WIDE_W-1:0] sx_base, sxx_base, sy_base, sxy_base;

  assign mag  = sample_i[DATA_W-1] ? -sample_i : sample_i;
  assign keep = (mag <= thresh_i);
  assign s_w  = WIDE_W'(sample_i);
  assign i_w  = WIDE_W'(idx_i);

  // channel 0 restarts the sums, no separate clear
  assign n_base   = first_i ? '0 : n_q;
  assign sx_base  = first_i ? '0 : sx_q;
  assign sxx_base = first_i ? '0 : sxx_q;
  assign sy_base  = first_i ? '0 : sy_q;
  assign sxy_base = first_i ? '0 : sxy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= '0;
      sx_q  <= '0;
      sxx_q <= '0;
      sy_q  <= '0;
      sxy_q <= '0;
    end else if (valid_i) begin
      n_q   <= n_base + CNT_W'(keep);
      sx_q  <= sx_base + (keep ? i_w : '0);
      sxx_q <= sxx_base + (keep ? i_w * i_w : '0);
      sy_q  <= sy_base + (keep ? s_w : '0);
      sxy_q <= sxy_base + (keep ? i_w * s_w : '0);
    end
  end

  assign n_o   = n_q;
  assign sx_o  = sx_q;
  assign sxx_o = sxx_q;
  assign sy_o  = sy_q;
  assign sxy_o = sxy_q;

endmodule

// File: rtl/cm_divider.sv
module cm_divider #(
  parameter int unsigned W = 36
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic signed [W-1:0] num_i,
  input  logic signed [W-1:0] den_i,
  output logic                done_o,
  output logic signed [W-1:0] quot_o
);

  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  num_mag, den_mag, quo_q, dmag_q;
  logic [W:0]    rem_q, rem_sh;
  logic [CW-1:0] cnt_q;
  logic          neg_q, run_q, done_q, ge;

  assign num_mag = num_i[W-1] ? W'(-num_i) : W'(num_i);
  assign den_mag = den_i[W-1] ? W'(-den_i) : W'(den_i);
  assign rem_sh  = {rem_q[W-1:0], quo_q[W-1]};
  assign ge      = (rem_sh >= {1'b0, dmag_q});

  // restoring, one quotient bit per cycle, result truncated toward zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dmag_q <= '0;
      cnt_q  <= '0;
      neg_q  <= 1'b0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        quo_q  <= num_mag;
        dmag_q <= den_mag;
        neg_q  <= num_i[W-1] ^ den_i[W-1];
        cnt_q  <= CW'(W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        if (ge) begin
          rem_q <= rem_sh - {1'b0, dmag_q};
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= rem_sh;
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = neg_q ? (~quo_q + W'(1)) : quo_q;

endmodule

// File: rtl/cm_apply.sv
module cm_apply #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OUT_W  = 8,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned WIDE_W = 36
) (
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic signed [WIDE_W-1:0] offs_i,
  input  logic signed [WIDE_W-1:0] slope_i,
  output logic signed [OUT_W-1:0]  data_o
);

  localparam logic signed [WIDE_W-1:0] MAX_V  = (WIDE_W'(1) <<< (OUT_W - 1)) - WIDE_W'(1);
  localparam logic signed [WIDE_W-1:0] MIN_V  = -MAX_V - WIDE_W'(1);
  localparam logic signed [WIDE_W-1:0] HALF_V = WIDE_W'(1) <<< (FRAC_W - 1);

  logic signed [WIDE_W-1:0] i_w, s_w, corr_fp, corr, diff;

  assign i_w     = WIDE_W'(idx_i);
  assign s_w     = WIDE_W'(sample_i);
  assign corr_fp = offs_i + slope_i * i_w + HALF_V;
  assign corr    = corr_fp >>> FRAC_W;
  assign diff    = s_w - corr;

  always_comb begin
    if (diff > MAX_V)      data_o = OUT_W'(MAX_V);
    else if (diff < MIN_V) data_o = OUT_W'(MIN_V);
    else                   data_o = OUT_W'(diff);
  end

endmodule

// File: rtl/cm_corrector.sv
module cm_corrector #(
  parameter int unsigned N_CH   = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OUT_W  = 8,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned IDX_W  = $clog2(N_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_data_i,
  input  logic                     mode_i,
  input  logic [DATA_W-1:0]        thresh_i,
  output logic                     busy_o,
  output logic                     out_valid_o,
  output logic [IDX_W-1:0]         out_chan_o,
  output logic signed [OUT_W-1:0]  out_data_o
);

  import cm_pkg::*;

  localparam int unsigned CNT_W  = $clog2(N_CH + 1);
  localparam int unsigned WIDE_W = wide_width(DATA_W, IDX_W, FRAC_W);
  localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(N_CH - 1);

  cm_state_e state_q;
  cm_mode_e  mode_q;
  logic [IDX_W-1:0]  chan_q;
  logic [DATA_W-1:0] thr_q, thr_eff;
  logic signed [DATA_W-1:0] slot_q [N_CH];
  logic signed [DATA_W-1:0] cur_s;
  logic take, ramp_ok;

  logic [CNT_W-1:0]         acc_n;
  logic signed [WIDE_W-1:0] acc_sx, acc_sxx, acc_sy, acc_sxy, n_w;
  logic signed [WIDE_W-1:0] num_b, den_b, num_a;
  logic signed [WIDE_W-1:0] div_num, div_den, div_q;
  logic signed [WIDE_W-1:0] slope_q, offs_q;
  logic                     div_start, div_done;
  logic signed [OUT_W-1:0]  corr_data;

  logic                    out_valid_q;
  logic [IDX_W-1:0]        out_chan_q;
  logic signed [OUT_W-1:0] out_data_q;

  assign take    = (state_q == ST_LOAD) && in_valid_i;
  assign thr_eff = (chan_q == '0) ? thresh_i : thr_q;
  assign cur_s   = slot_q[chan_q];

  cm_stats #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .WIDE_W(WIDE_W)
  ) u_stats (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (take),
    .first_i (chan_q == '0),
    .idx_i   (chan_q),
    .sample_i(in_data_i),
    .thresh_i(thr_eff),
    .n_o     (acc_n),
    .sx_o    (acc_sx),
    .sxx_o   (acc_sxx),
    .sy_o    (acc_sy),
    .sxy_o   (acc_sxy)
  );

  // least-squares numerators; slope first, offset reuses the slope result
  assign n_w     = WIDE_W'(acc_n);
  assign num_b   = (n_w * acc_sxy - acc_sx * acc_sy) <<< FRAC_W;
  assign den_b   = n_w * acc_sxx - acc_sx * acc_sx;
  assign num_a   = (acc_sy <<< FRAC_W) - slope_q * acc_sx;
  assign ramp_ok = (mode_q == MODE_RAMP) && (acc_n >= CNT_W'(2));

  assign div_start = ((state_q == ST_SLOPE) && ramp_ok) ||
                     ((state_q == ST_OFFS) && (acc_n != '0));
  assign div_num   = (state_q == ST_SLOPE) ? num_b : num_a;
  assign div_den   = (state_q == ST_SLOPE) ? den_b : n_w;

  cm_divider #(.W(WIDE_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (div_num),
    .den_i  (div_den),
    .done_o (div_done),
    .quot_o (div_q)
  );

  cm_apply #(
    .DATA_W(DATA_W), .OUT_W(OUT_W), .IDX_W(IDX_W), .FRAC_W(FRAC_W), .WIDE_W(WIDE_W)
  ) u_apply (
    .sample_i(cur_s),
    .idx_i   (chan_q),
    .offs_i  (offs_q),
    .slope_i (slope_q),
    .data_o  (corr_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(N_CH); k++) slot_q[k] <= '0;
    end else if (take) begin
      for (int k = 0; k < int'(N_CH); k++)
        if (chan_q == IDX_W'(k)) slot_q[k] <= in_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_LOAD;
      mode_q      <= MODE_FLAT;
      thr_q       <= '0;
      chan_q      <= '0;
      slope_q     <= '0;
      offs_q      <= '0;
      out_valid_q <= 1'b0;
      out_chan_q  <= '0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= 1'b0;
      unique case (state_q)
        ST_LOAD: begin
          if (take) begin
            if (chan_q == '0) begin
              mode_q <= cm_mode_e'(mode_i);
              thr_q  <= thresh_i;
            end
            if (chan_q == LAST_CH) begin
              chan_q  <= '0;
              state_q <= ST_SLOPE;
            end else begin
              chan_q <= chan_q + IDX_W'(1);
            end
          end
        end
        ST_SLOPE: begin
          if (ramp_ok) begin
            state_q <= ST_DIV_B;
          end else begin
            slope_q <= '0;
            state_q <= ST_OFFS;
          end
        end
        ST_DIV_B: begin
          if (div_done) begin
            slope_q <= div_q;
            state_q <= ST_OFFS;
          end
        end
        ST_OFFS: begin
          if (acc_n == '0) begin
            offs_q  <= '0;
            state_q <= ST_OUT;
          end else begin
            state_q <= ST_DIV_A;
          end
        end
        ST_DIV_A: begin
          if (div_done) begin
            offs_q  <= div_q;
            state_q <= ST_OUT;
          end
        end
        ST_OUT: begin
          out_valid_q <= 1'b1;
          out_chan_q  <= chan_q;
          out_data_q  <= corr_data;
          if (chan_q == LAST_CH) begin
            chan_q  <= '0;
            state_q <= ST_LOAD;
          end else begin
            chan_q <= chan_q + IDX_W'(1);
          end
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_LOAD);
  assign out_valid_o = out_valid_q;
  assign out_chan_o  = out_chan_q;
  assign out_data_o  = out_data_q;

endmodule

// File: rtl/cm_corrector_chk.sv
module cm_corrector_chk #(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             busy_o,
  input logic             out_valid_o,
  input logic [IDX_W-1:0] out_chan_o,
  input logic [CNT_W-1:0] acc_n_i
);

  localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(N_CH - 1);

  p_load_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(in_valid_i));

  p_busy_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> $stable(acc_n_i));

  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_n_i <= CNT_W'(N_CH));

  p_first_chan_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> (out_chan_o == '0));

  p_chan_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_chan_o != LAST_CH) |=>
      (out_valid_o && out_chan_o == $past(out_chan_o) + IDX_W'(1)));

  p_busy_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (out_valid_o && out_chan_o == LAST_CH));

  p_out_in_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_chan_o != LAST_CH) |-> busy_o);

endmodule

bind cm_corrector cm_corrector_chk #(
  .N_CH (N_CH),
  .IDX_W(IDX_W),
  .CNT_W(CNT_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .busy_o     (busy_o),
  .out_valid_o(out_valid_o),
  .out_chan_o (out_chan_o),
  .acc_n_i    (acc_n)
);

// File: tb/test_cm_corrector.sv
module test_cm_corrector;

  localparam int N  = 16;
  localparam int DW = 8;
  localparam int OW = 8;
  localparam int FW = 8;
  localparam int IW = $clog2(N);

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic                 rst_ni;
  logic                 in_valid_i;
  logic signed [DW-1:0] in_data_i;
  logic                 mode_i;
  logic [DW-1:0]        thresh_i;
  logic                 busy_o;
  logic                 out_valid_o;
  logic [IW-1:0]        out_chan_o;
  logic signed [OW-1:0] out_data_o;

  cm_corrector #(.N_CH(N), .DATA_W(DW), .OUT_W(OW), .FRAC_W(FW)) i_cm_corrector (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .mode_i(mode_i), .thresh_i(thresh_i), .busy_o(busy_o), .out_valid_o(out_valid_o),
    .out_chan_o(out_chan_o), .out_data_o(out_data_o)
  );

  int errors = 0;
  int checks = 0;
  logic signed [DW-1:0] smp [N];
  int exp_v [N];

  // frame recipe: sample i = off + (slope4*i)/4, channel hit_ch replaced by hit_val (-1: none)
  typedef struct packed {
    logic              lin;
    logic [7:0]        thr;
    logic signed [7:0] off;
    logic signed [7:0] slope4;
    logic signed [7:0] hit_ch;
    logic signed [7:0] hit_val;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 8'd40,  8'sd5,   8'sd0,  -8'sd1,  8'sd0},    // R4 flat, no hit
    '{1'b0, 8'd40, -8'sd7,   8'sd0,   8'sd3,  8'sd100},  // R3 R4 hit rejected
    '{1'b1, 8'd60, -8'sd10,  8'sd8,  -8'sd1,  8'sd0},    // R5 exact ramp
    '{1'b1, 8'd60,  8'sd12, -8'sd6,   8'sd9, -8'sd90},   // R5 ramp with hit
    '{1'b0, 8'd30,  8'sd20,  8'sd0,   8'sd0, -8'sd128},  // R8 clamp low
    '{1'b0, 8'd30, -8'sd20,  8'sd0,   8'sd15, 8'sd127},  // R8 clamp high
    '{1'b1, 8'd255, 8'sd3,   8'sd5,  -8'sd1,  8'sd0},    // R5 all accepted
    '{1'b0, 8'd0,   8'sd0,   8'sd0,  -8'sd1,  8'sd0},    // R3 zero threshold
    '{1'b0, 8'd20,  8'sd20,  8'sd0,   8'sd2, -8'sd21}    // R3 equal accepted, one over
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic void build(input vec_t v);
    for (int i = 0; i < N; i++) begin
      int s;
      s = int'(v.off) + (int'(v.slope4) * i) / 4;
      if (i == int'(v.hit_ch)) s = int'(v.hit_val);
      if (s > 127) s = 127;
      if (s < -128) s = -128;
      smp[i] = DW'(s);
    end
  endfunction

  function automatic void model(input logic lin, input int thr);
    longint n, sx, sxx, sy, sxy, b, a, c, d;
    n = 0; sx = 0; sxx = 0; sy = 0; sxy = 0;
    for (int i = 0; i < N; i++) begin
      longint y, m;
      y = longint'(smp[i]);
      m = (y < 0) ? -y : y;
      if (m <= longint'(thr)) begin
        n++; sx += i; sxx += i * i; sy += y; sxy += i * y;
      end
    end
    b = 0;
    if (lin && n >= 2) b = ((n * sxy - sx * sy) * (64'sd1 <<< FW)) / (n * sxx - sx * sx);
    a = 0;
    if (n > 0) a = (sy * (64'sd1 <<< FW) - b * sx) / n;
    for (int i = 0; i < N; i++) begin
      c = (a + b * i + (64'sd1 <<< (FW - 1))) >>> FW;
      d = longint'(smp[i]) - c;
      if (d > 127) d = 127;
      if (d < -128) d = -128;
      exp_v[i] = int'(d);
    end
  endfunction

  task automatic run_frame(input logic lin, input int thr, input bit junk, input string req);
    int got, guard;
    model(lin, thr);
    for (int i = 0; i < N; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1;
      in_data_i  = smp[i];
      mode_i     = lin;
      thresh_i   = DW'(thr);
    end
    @(negedge clk_i);
    check(busy_o == 1'b1, "R1", "busy after load", int'(busy_o), 1);
    if (junk) begin
      in_valid_i = 1'b1;
      in_data_i  = 8'sd99;
      mode_i     = ~lin;
      thresh_i   = '0;
    end else begin
      in_valid_i = 1'b0;
    end
    got = 0;
    guard = 0;
    while (got < N && guard < 2000) begin
      if (out_valid_o) begin
        check(int'(out_chan_o) == got, "R9", "channel order", int'(out_chan_o), got);
        check(int'(out_data_o) == exp_v[got], req, $sformatf("data ch%0d", got),
              int'(out_data_o), exp_v[got]);
        got++;
        if (got == N) begin
          in_valid_i = 1'b0;
          check(busy_o == 1'b0, "R9", "busy low at last output", int'(busy_o), 0);
        end
      end
      if (got < N) @(negedge clk_i);
      guard++;
    end
    if (got < N) check(1'b0, "R9", "outputs received", got, N);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; in_valid_i = 1'b0; in_data_i = '0; mode_i = 1'b0; thresh_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    check(busy_o == 1'b0, "R10", "busy after reset", int'(busy_o), 0);
    check(out_valid_o == 1'b0, "R10", "valid after reset", int'(out_valid_o), 0);

    for (int v = 0; v < 9; v++) begin
      build(VECS[v]);
      run_frame(VECS[v].lin, int'(VECS[v].thr), 1'b0, $sformatf("vec%0d R4/R5/R8", v));
    end

    // R7: every sample over threshold, output equals input
    for (int i = 0; i < N; i++) smp[i] = DW'(50 + i);
    run_frame(1'b1, 2, 1'b0, "R7");

    // R6: ramp mode, single accepted sample -> flat offset of 4
    for (int i = 0; i < N; i++) smp[i] = 8'sd60;
    smp[5] = 8'sd4;
    run_frame(1'b1, 10, 1'b0, "R6");

    // R2: junk held during busy, then a clean frame
    build(VECS[3]);
    run_frame(1'b1, 60, 1'b1, "R2");
    build(VECS[1]);
    run_frame(1'b0, 40, 1'b0, "R2");

    repeat (3) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule